// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor that completes one instruction in every clock cycle. It fetches a word from an internal instruction store at the program counter and decodes it. It reads two operands from a 32-entry register file, runs them through an adder/subtractor/OR unit, and in the same cycle commits the result to a register, to the internal data store, or to the program counter. The instruction set is limited to register add and subtract, OR with an immediate, word load, word store and branch-if-equal.

Control is split into two levels. A main decoder looks only at the opcode and produces the datapath selects plus a two-bit operation class. A small local decoder turns that class, together with the function field of register-format words, into the ALU operation. The instruction and data stores are plain word arrays named `imem` and `dmem` inside the core. Before reset is released, a test environment fills them by hierarchical assignment. The core's write strobes for the register file and the data store are driven out as ports so that their effects can be watched from outside.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 at the next rising edge. While `rst` is high, no register write and no data-store write takes place.
- R2: Opcode 000000 is register format: rd (bits 15:11) receives rs (bits 25:21) plus rt (bits 20:16) when funct (bits 5:0) is 100000, and rs minus rt when funct is 100010.
- R3: Opcode 001101 writes rs OR the zero-extended 16-bit immediate (bits 15:0) into rt.
- R4: Opcode 100011 loads the data word at address rs plus the sign-extended immediate into rt.
- R5: Opcode 101011 writes rt to the data word at address rs plus the sign-extended immediate, and writes no register.
- R6: Opcode 000100 compares rs with rt by subtraction. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by two. Otherwise the next PC is PC+4. It writes neither a register nor the data store.
- R7: Register 0 always reads as zero. A write aimed at it is dropped, so `rf_we_o` stays low.
- R8: Any other opcode acts as a no-op: no register write, no store, and the PC advances by 4.
- R9: Every instruction other than a taken branch advances the PC by 4.
- R10: Both stores are word-addressed by address bits 31:2. Reads are combinational and writes occur on the rising edge, so a load in the cycle right after a store to the same address returns the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Current program counter (byte address) |
| rf_we_o | output | 1 | A register write commits at the coming edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value being written to the register |
| mem_we_o | output | 1 | A data-store write commits at the coming edge |
| mem_addr_o | output | 32 | Byte address computed for the load or store |
| mem_wdata_o | output | 32 | Word being stored |

## Verification
The functions that meet in one cycle are the edge-triggered commit of one instruction and the combinational read of the next instruction. A store followed at once by a load from the same word tests this: the load must return the new word and not the old one. A branch that compares a register written by the preceding load tests the same thing in the register file. The program checks the loaded value and the branch direction on the cycle after each commit. It also lays out a write to register 0 followed by a read of register 0, and a backward branch that targets itself, so that the results of zeroing and of negative offsets can be seen at `pc_o` and at the write-back ports.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN    = 32;
    localparam int REG_CNT = 32;
    localparam int RIDX    = $clog2(REG_CNT);

    localparam logic [5:0] OPC_REG  = 6'b000000;
    localparam logic [5:0] OPC_ORI  = 6'b001101;
    localparam logic [5:0] OPC_LOAD = 6'b100011;
    localparam logic [5:0] OPC_STOR = 6'b101011;
    localparam logic [5:0] OPC_BEQ  = 6'b000100;

    localparam logic [5:0] FUN_ADD  = 6'b100000;
    localparam logic [5:0] FUN_SUB  = 6'b100010;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_OR    = 2'b10,
        CLS_FUNCT = 2'b11
    } op_class_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_fn_e;

    typedef struct packed {
        logic      reg_write;
        logic      dst_is_rd;
        logic      b_is_imm;
        logic      sign_ext;
        logic      mem_write;
        logic      load_wb;
        logic      branch;
        op_class_e op_class;
    } ctrl_t;

    function automatic logic [XLEN-1:0] extend16(input logic [15:0] imm, input logic sgn);
        return {{(XLEN-16){sgn & imm[15]}}, imm};
    endfunction

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{reg_write: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0, sign_ext: 1'b0,
                 mem_write: 1'b0, load_wb: 1'b0, branch: 1'b0, op_class: CLS_ADD};
        case (opcode)
            OPC_REG: begin
                ctrl.reg_write = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.op_class  = CLS_FUNCT;
            end
            OPC_ORI: begin
                ctrl.reg_write = 1'b1;
                ctrl.b_is_imm  = 1'b1;
                ctrl.op_class  = CLS_OR;
            end
            OPC_LOAD: begin
                ctrl.reg_write = 1'b1;
                ctrl.b_is_imm  = 1'b1;
                ctrl.sign_ext  = 1'b1;
                ctrl.load_wb   = 1'b1;
            end
            OPC_STOR: begin
                ctrl.b_is_imm  = 1'b1;
                ctrl.sign_ext  = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.sign_ext  = 1'b1;
                ctrl.branch    = 1'b1;
                ctrl.op_class  = CLS_SUB;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_pkg::*;
(
    input  op_class_e  op_class,
    input  logic [5:0] funct,
    output alu_fn_e    fn
);
    always_comb begin
        case (op_class)
            CLS_SUB:   fn = ALU_SUB;
            CLS_OR:    fn = ALU_OR;
            CLS_FUNCT: fn = (funct == FUN_SUB) ? ALU_SUB : ALU_ADD;
            default:   fn = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (fn)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);
    logic [W-1:0] regs [1:NREG-1];

    always_ff @(posedge clk) begin
        if (we && waddr != '0) regs[waddr] <= wdata;
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

    AST_RF_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata)); // R10
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] pc_o,
    output logic            rf_we_o,
    output logic [RIDX-1:0] rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o,
    output logic            mem_we_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o
);
    localparam int IA = $clog2(IMEM_WORDS);
    localparam int DA = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_plus4, br_target, pc_next;
    logic [XLEN-1:0] instr, imm_ext, opa, opb_reg, opb, alu_y, ld_data, wb_data;
    logic [RIDX-1:0] wb_reg;
    logic [IA-1:0]   im_idx;
    logic [DA-1:0]   dm_idx;
    logic            alu_zero, rf_we, dm_we;
    ctrl_t           ctrl;
    alu_fn_e         fn;

    assign im_idx = IA'(pc_q >> 2);
    assign instr  = imem[im_idx];

    sc_main_dec u_main (.opcode(instr[31:26]), .ctrl(ctrl));
    sc_alu_dec  u_adec (.op_class(ctrl.op_class), .funct(instr[5:0]), .fn(fn));

    assign wb_reg = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
    assign rf_we  = ctrl.reg_write & ~rst;

    sc_regfile #(.NREG(REG_CNT), .W(XLEN)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(wb_reg), .wdata(wb_data),
        .ra_a(instr[25:21]), .ra_b(instr[20:16]), .rd_a(opa), .rd_b(opb_reg)
    );

    assign imm_ext = extend16(instr[15:0], ctrl.sign_ext);
    assign opb     = ctrl.b_is_imm ? imm_ext : opb_reg;

    sc_alu #(.W(XLEN)) u_alu (.a(opa), .b(opb), .fn(fn), .y(alu_y), .zero(alu_zero));

    assign dm_idx  = DA'(alu_y >> 2);
    assign ld_data = dmem[dm_idx];
    assign wb_data = ctrl.load_wb ? ld_data : alu_y;
    assign dm_we   = ctrl.mem_write & ~rst;

    assign pc_plus4  = pc_q + XLEN'(4);
    assign br_target = pc_plus4 + (imm_ext << 2);
    assign pc_next   = (ctrl.branch && alu_zero) ? br_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    always_ff @(posedge clk) begin
        if (dm_we) dmem[dm_idx] <= opb_reg;
    end

    assign pc_o        = pc_q;
    assign rf_we_o     = rf_we && (wb_reg != '0);
    assign rf_waddr_o  = wb_reg;
    assign rf_wdata_o  = wb_data;
    assign mem_we_o    = dm_we;
    assign mem_addr_o  = alu_y;
    assign mem_wdata_o = opb_reg;

    AST_RST_PC: assert property (@(posedge clk) rst |=> pc_q == '0); // R1
    AST_STEP_PC: assert property (@(posedge clk) disable iff (rst)
        !ctrl.branch |=> pc_q == $past(pc_q) + XLEN'(4)); // R9
    AST_BR_FALL: assert property (@(posedge clk) disable iff (rst)
        (ctrl.branch && !alu_zero) |=> pc_q == $past(pc_q) + XLEN'(4)); // R6
    AST_EXCL_WR: assert property (@(posedge clk) disable iff (rst)
        !(rf_we_o && mem_we_o)); // R5
    AST_DM_COMMIT: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |=> dmem[$past(dm_idx)] == $past(opb_reg)); // R10
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] instr;
        logic        rwe;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        mwe;
        logic [31:0] ma;
        logic [31:0] md;
    } row_t;

    localparam int NROW = 14;
    // pc, instruction, reg write?, reg, value, store?, address, data
    localparam row_t ROWS [NROW] = '{
        '{32'd0,  32'h34010005, 1'b1, 5'd1, 32'h00000005, 1'b0, 32'h0, 32'h0}, // R3 ori r1,r0,5
        '{32'd4,  32'h3402FFFF, 1'b1, 5'd2, 32'h0000FFFF, 1'b0, 32'h0, 32'h0}, // R3 zero extension
        '{32'd8,  32'h00221820, 1'b1, 5'd3, 32'h00010004, 1'b0, 32'h0, 32'h0}, // R2 add r3
        '{32'd12, 32'h00222022, 1'b1, 5'd4, 32'hFFFF0006, 1'b0, 32'h0, 32'h0}, // R2 sub r4
        '{32'd16, 32'hAC230003, 1'b0, 5'd0, 32'h0,        1'b1, 32'h8, 32'h00010004}, // R5 sw r3,3(r1)
        '{32'd20, 32'h8C250003, 1'b1, 5'd5, 32'h00010004, 1'b0, 32'h0, 32'h0}, // R10 lw after sw
        '{32'd24, 32'h8C26FFFB, 1'b1, 5'd6, 32'hCAFE0001, 1'b0, 32'h0, 32'h0}, // R4 negative offset
        '{32'd28, 32'h00210020, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0}, // R7 write r0 dropped
        '{32'd32, 32'h00013820, 1'b1, 5'd7, 32'h00000005, 1'b0, 32'h0, 32'h0}, // R7 r0 reads 0
        '{32'd36, 32'h10220008, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0}, // R6 not taken
        '{32'd40, 32'h10A30002, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0}, // R6 taken to 52
        '{32'd52, 32'hFC000000, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0}, // R8 unknown opcode
        '{32'd56, 32'h1000FFFF, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0}, // R9 pc+4 after no-op
        '{32'd56, 32'h1000FFFF, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0}  // R6 backward self
    };

    function automatic string row_req(input int i);
        case (i)
            0, 1:    return "R3";
            2, 3:    return "R2";
            4:       return "R5";
            5:       return "R10";
            6:       return "R4";
            7, 8:    return "R7";
            11:      return "R8";
            12:      return "R9";
            default: return "R6";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o, rf_wdata_o, mem_addr_o, mem_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, mem_we_o;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    sc_core u0 (
        .clk(clk), .rst(rst), .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
        .rf_wdata_o(rf_wdata_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            u0.imem[i] = 32'hFC000000;
            u0.dmem[i] = 32'h0;
        end
        for (int i = 0; i < NROW; i++) u0.imem[ROWS[i].pc >> 2] = ROWS[i].instr;
        u0.imem[11] = 32'h34080077;  // skipped by the taken branch
        u0.imem[12] = 32'h34080078;
        u0.dmem[0]  = 32'hCAFE0001;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pc in reset", pc_o, 32'h0);
        chk("R1", "reg write in reset", {31'h0, rf_we_o}, 32'h0);
        rst = 1'b0;
        #1;
        for (int i = 0; i < NROW; i++) begin
            if (i > 0) @(negedge clk);
            chk(row_req(i), "pc", pc_o, ROWS[i].pc);
            chk(row_req(i), "reg we", {31'h0, rf_we_o}, {31'h0, ROWS[i].rwe});
            if (ROWS[i].rwe) begin
                chk(row_req(i), "reg addr", {27'h0, rf_waddr_o}, {27'h0, ROWS[i].wa});
                chk(row_req(i), "reg data", rf_wdata_o, ROWS[i].wd);
            end
            chk(row_req(i), "store we", {31'h0, mem_we_o}, {31'h0, ROWS[i].mwe});
            if (ROWS[i].mwe) begin
                chk(row_req(i), "store addr", mem_addr_o, ROWS[i].ma);
                chk(row_req(i), "store data", mem_wdata_o, ROWS[i].md);
            end
        end

        // R1: reset in the middle of a run
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "pc after mid-run reset", pc_o, 32'h0);
        chk("R1", "no store in reset", {31'h0, mem_we_o}, 32'h0);
        rst = 1'b0;
        #1;
        chk("R1", "first word after reset", rf_wdata_o, 32'h5);
        @(negedge clk);
        chk("R9", "pc after restart", pc_o, 32'h4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule